// File: doc/BRIEF.md
# Bit-masked write control register bank

This block holds a small set of 16-bit control registers behind a simple memory-mapped request port. Every write word carries its own per-bit enable mask: the upper half of the 32-bit data selects which bits of the lower half take effect. Software can therefore change a single field without first reading the register back. Bits whose enable is clear keep their current value.

The bank has eight control registers, one word apart from offset 0x00. A read-only status word sits directly above them at offset 0x20. The block drives the decoded analog-control fields as output ports. These are power enable, DLL enable, drive strength, clock-frequency select, output tap-delay enable and tap-delay select. All eight raw registers are also driven as one flat vector. Status reads return two live inputs: calibration done and DLL ready.

Every request is accepted in the cycle it is presented. A response follows exactly one cycle later. Any access the bank cannot honour is ignored and flagged with an error on that response.

Top module: `masked_ctl_bank`

## Requirements
- R1: On a write to control register i (byte offset 4*i, i = 0..7), lower bit x takes data bit x when data bit x+16 is 1, and otherwise keeps its value.
- R2: A write whose upper 16 bits are all zero leaves the register unchanged, and its response has rsp_err = 0.
- R3: After reset, every control register reads 0, except register 0, which reads 0x0200 (tap-delay select = 4).
- R4: A read of a mapped offset returns 0 in bits 31:16 and the current 16-bit contents in bits 15:0.
- R5: A read of offset 0x20 returns cal_done_i in bit 6 and dll_ready_i in bit 5, with every other bit 0.
- R6: Writes to 0x20, and any access to an offset that is not a multiple of 4 or lies above 0x20, change no register. Their response carries rsp_err = 1 for that single cycle, and such reads return 0.
- R7: The field ports follow the registers. From register 6: pwr_on = bit 0, dll_en = bit 1, drv_sel = bits 6:4. From register 0: freq_sel = bits 13:12, tap_en = bit 11, tap_sel = bits 10:7. ctl_q[16*i+15:16*i] equals register i.
- R8: req_ready is always 1. rsp_valid is 1 in exactly the cycle after a cycle with req_valid = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Byte offset |
| req_wdata | input | 32 | Bits 31:16 are the bit enables, bits 15:0 the data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access was to an unmapped or read-only offset |
| cal_done_i | input | 1 | Calibration done status |
| dll_ready_i | input | 1 | DLL ready status |
| pwr_on | output | 1 | Analog power enable |
| dll_en | output | 1 | DLL enable |
| drv_sel | output | 3 | Drive strength code (0 = 50, 1 = 33, 2 = 66, 3 = 100, 4 = 40 ohm) |
| freq_sel | output | 2 | Clock select (0 = 200, 1 = 50, 2 = 100, 3 = 150 MHz) |
| tap_en | output | 1 | Output tap-delay enable |
| tap_sel | output | 4 | Output tap-delay select |
| ctl_q | output | 128 | All control registers, register i in bits 16*i+15:16*i |

## Verification
The properties assume that req_write and req_addr are meaningful only while req_valid is high, and that request inputs change only between clock edges. They do not assume any limit on back-to-back requests. The stimulus drives each request on a falling edge for exactly one cycle. It sweeps all 64 offsets, and it walks every enable bit of every register with both data polarities. The status inputs change only while no status read is in flight.

// File: rtl/masked_ctl_bank.sv
module masked_ctl_bank #(
  parameter int NREG    = 8,
  parameter int ADDR_W  = 6,
  parameter int TAP_RST = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [31:0]          req_wdata,
  output logic                 rsp_valid,
  output logic [31:0]          rsp_rdata,
  output logic                 rsp_err,
  input  logic                 cal_done_i,
  input  logic                 dll_ready_i,
  output logic                 pwr_on,
  output logic                 dll_en,
  output logic [2:0]           drv_sel,
  output logic [1:0]           freq_sel,
  output logic                 tap_en,
  output logic [3:0]           tap_sel,
  output logic [NREG*16-1:0]   ctl_q
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] STAT_OFF = ADDR_W'(NREG * 4);

  logic [15:0] regs [NREG];
  logic [IDX_W-1:0] idx;
  logic is_ctl, is_stat, wr_ok, bad;
  logic [15:0] rd_val;
  logic [15:0] mask;

  assign idx       = req_addr[ADDR_W-1:2];
  assign is_ctl    = (req_addr[1:0] == 2'b00) && (32'(idx) < NREG);
  assign is_stat   = (req_addr == STAT_OFF);
  assign wr_ok     = req_valid && req_write && is_ctl;
  assign bad       = !is_ctl && !(is_stat && !req_write);
  assign mask      = req_wdata[31:16];
  assign req_ready = 1'b1;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [15:0] RST = (i == 0) ? 16'(TAP_RST << 7) : 16'h0000;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[i] <= RST;
      else if (wr_ok && idx == IDX_W'(i))
        regs[i] <= (regs[i] & ~mask) | (req_wdata[15:0] & mask);
    end
    assign ctl_q[16*i +: 16] = regs[i];
  end

  always_comb begin
    rd_val = 16'h0000;
    if (is_ctl)
      rd_val = regs[idx];
    else if (is_stat)
      rd_val = {9'b0, cal_done_i, dll_ready_i, 5'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= 32'h0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && bad;
      rsp_rdata <= (req_valid && !req_write) ? {16'h0000, rd_val} : 32'h0;
    end
  end

  assign pwr_on   = regs[6][0];
  assign dll_en   = regs[6][1];
  assign drv_sel  = regs[6][6:4];
  assign freq_sel = regs[0][13:12];
  assign tap_en   = regs[0][11];
  assign tap_sel  = regs[0][10:7];
endmodule

module masked_ctl_bank_chk #(
  parameter int NREG   = 8,
  parameter int ADDR_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [31:0]        req_wdata,
  input logic               rsp_valid,
  input logic               rsp_err,
  input logic [31:0]        rsp_rdata,
  input logic [NREG*16-1:0] ctl_q
);
  localparam logic [ADDR_W-1:0] STAT_OFF = ADDR_W'(NREG * 4);

  p_rsp_follows_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_rsp_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_err_with_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);
  p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_rdata[31:16] == 16'h0);
  p_zero_mask_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_wdata[31:16] == 16'h0) |=> $stable(ctl_q));
  p_status_wr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == STAT_OFF) |=> ($stable(ctl_q) && rsp_err));
  p_idle_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(ctl_q));
endmodule

bind masked_ctl_bank masked_ctl_bank_chk #(.NREG(NREG), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .ctl_q(ctl_q));

// File: tb/masked_ctl_bank_bench.sv
module masked_ctl_bank_bench;
  localparam int CLK_NS = 10;
  localparam int NREG = 8;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [5:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic cal_done_i = 0, dll_ready_i = 0;
  logic pwr_on, dll_en, tap_en;
  logic [2:0] drv_sel;
  logic [1:0] freq_sel;
  logic [3:0] tap_sel;
  logic [NREG*16-1:0] ctl_q;

  int nchk = 0, nerr = 0;
  logic [15:0] m [NREG];
  logic [31:0] rd;
  logic e, v;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_NS/2) clk = ~clk;

  masked_ctl_bank u_masked_ctl_bank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .cal_done_i(cal_done_i), .dll_ready_i(dll_ready_i), .pwr_on(pwr_on),
    .dll_en(dll_en), .drv_sel(drv_sel), .freq_sel(freq_sel), .tap_en(tap_en),
    .tap_sel(tap_sel), .ctl_q(ctl_q));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    rd = rsp_rdata; e = rsp_err; v = rsp_valid;
    check("R8 rsp_valid", {31'b0, v}, 32'd1);
    check("R8 req_ready", {31'b0, req_ready}, 32'd1);
  endtask

  task automatic mwrite(input int r, input logic [15:0] msk, input logic [15:0] dat);
    xfer(1, 6'(r*4), {msk, dat});
    m[r] = (m[r] & ~msk) | (dat & msk);
    check("R2 write no error", {31'b0, e}, 32'd0);
  endtask

  task automatic verify_all(input string tag);
    for (int r = 0; r < NREG; r++) begin
      xfer(0, 6'(r*4), 32'h0);
      check(tag, rd, {16'h0, m[r]});
      check("R7 ctl_q slice", {16'h0, ctl_q[16*r +: 16]}, {16'h0, m[r]});
    end
  endtask

  task automatic check_fields();
    check("R7 pwr_on", {31'b0, pwr_on}, {31'b0, m[6][0]});
    check("R7 dll_en", {31'b0, dll_en}, {31'b0, m[6][1]});
    check("R7 drv_sel", {29'b0, drv_sel}, {29'b0, m[6][6:4]});
    check("R7 freq_sel", {30'b0, freq_sel}, {30'b0, m[0][13:12]});
    check("R7 tap_en", {31'b0, tap_en}, {31'b0, m[0][11]});
    check("R7 tap_sel", {28'b0, tap_sel}, {28'b0, m[0][10:7]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    for (int r = 0; r < NREG; r++) m[r] = (r == 0) ? 16'h0200 : 16'h0000;
    repeat (3) @(negedge clk);
    check("R8 rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
    rst_n = 1;
    check("R3 tap_sel reset", {28'b0, tap_sel}, 32'd4);
    check_fields();
    verify_all("R3 reset readback");

    for (int r = 0; r < NREG; r++)
      for (int b = 0; b < 16; b++) begin
        mwrite(r, 16'(1 << b), 16'hFFFF);
        xfer(0, 6'(r*4), 0); check("R1 single bit set", rd, {16'h0, m[r]});
        mwrite(r, 16'(1 << b), 16'h0000);
        xfer(0, 6'(r*4), 0); check("R1 single bit clear", rd, {16'h0, m[r]});
      end

    for (int k = 0; k < 200; k++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      mwrite(int'(seed[30:28]), seed[15:0], seed[27:12]);
      if (k % 25 == 0) begin verify_all("R4 readback"); check_fields(); end
    end
    verify_all("R4 readback after sweep");

    for (int k = 0; k < 8; k++) begin
      xfer(1, 6'(k*4), {16'h0000, 16'(16'hA5A5 ^ k)});
      check("R2 zero mask no error", {31'b0, e}, 32'd0);
    end
    verify_all("R2 zero mask unchanged");

    for (int d = 0; d < 5; d++) begin mwrite(6, 16'h0070, 16'(d << 4)); check_fields(); end
    for (int f = 0; f < 4; f++) begin mwrite(0, 16'h3000, 16'(f << 12)); check_fields(); end
    for (int t = 0; t < 16; t++) begin mwrite(0, 16'h0F80, 16'(t << 7)); check_fields(); end
    mwrite(0, 16'h0800, 16'h0800); mwrite(6, 16'h0003, 16'h0003); check_fields();
    mwrite(6, 16'h0001, 16'h0000); check_fields();

    for (int s = 0; s < 4; s++) begin
      @(negedge clk); cal_done_i = s[1]; dll_ready_i = s[0];
      xfer(0, 6'h20, 0);
      check("R5 status read", rd, {25'b0, s[1], s[0], 5'b0});
      check("R5 status read no error", {31'b0, e}, 32'd0);
    end

    for (int a = 0; a < 64; a++) begin
      logic ok;
      ok = (a % 4 == 0) && (a <= 32);
      xfer(0, 6'(a), 0);
      check("R6 read err flag", {31'b0, e}, {31'b0, !ok});
      if (!ok) check("R6 unmapped read zero", rd, 32'h0);
      if (a % 4 == 0 && a < 32) check("R4 sweep read", rd, {16'h0, m[a/4]});
      if (a % 4 != 0 || a >= 32) begin
        xfer(1, 6'(a), 32'hFFFF_FFFF);
        check("R6 write err flag", {31'b0, e}, 32'd1);
        @(negedge clk);
        check("R6 err one cycle", {31'b0, rsp_err}, 32'd0);
      end
    end
    verify_all("R6 no register changed");
    check_fields();

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule